// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block sits between the reset logic and the bus port of a small processor core. When reset is released it reads the first two words of a vector table at a fixed base address. It keeps the first word as the initial stack pointer and the second word as the reset handler address for the program counter. It holds the core off until both values are in place, so that a valid stack exists before any instruction runs.

The reads use a simple request/ready bus. The block raises a request with a word address and keeps it stable until the responder signals ready in the same cycle. At that point the read data is taken. Once both words are captured, the block pulses a load strobe so the core can copy the two values, and then enables the core. A handler address whose marker bit (bit 0 by default) is clear is treated as a broken table. The block then raises an error flag and never enables the core. Driving reset low at any time drops the core enable at once and starts the whole sequence again.

Top module: `boot_vec_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `core_en`, `bus_req`, `load_stb` and `vec_err` low and `sp_out`, `pc_out` zero.
- R2: In the cycle after the first clock edge with `rst_n` high, `bus_req` is high with `bus_addr` equal to the table base (0x0000_0000 by default).
- R3: While `bus_req` is high and `bus_ready` is low, the request and the address stay unchanged in the next cycle, so any number of wait cycles is accepted.
- R4: The word returned on the clock edge where the first read (base + 0x00) sees `bus_ready` high appears on `sp_out` from the next cycle on.
- R5: In the cycle after the first read completes, `bus_req` is high with `bus_addr` equal to base + 0x04. The two reads never change order.
- R6: The word returned by the second read appears on `pc_out` from the cycle after that read completes.
- R7: `core_en` stays low until both reads are done. If bit 0 of the second word is 1, then in the cycle after that read `core_en` goes high and `load_stb` is high for exactly that one cycle.
- R8: If bit 0 of the second word is 0, `vec_err` goes high in the next cycle and stays high. `core_en` and `bus_req` then stay low until reset.
- R9: Whenever `rst_n` is low, `core_en` and `bus_req` are low in that same cycle. After release, the sequence restarts with the read at the base address.
- R10: While `core_en` is high, `bus_req` stays low and `sp_out`/`pc_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | output | 1 | Read request to the vector table |
| bus_addr | output | ADDR_W | Byte address of the requested word |
| bus_ready | input | 1 | Read data valid; completes the request this cycle |
| bus_rdata | input | DATA_W | Read data |
| sp_out | output | DATA_W | Captured initial stack pointer |
| pc_out | output | DATA_W | Captured reset handler address |
| load_stb | output | 1 | One-cycle pulse when both values are valid |
| core_en | output | 1 | Core may start fetching instructions |
| vec_err | output | 1 | Handler address failed the marker-bit check |

## Verification
The fetch sequence is run with zero-wait responses and with several wait cycles on each read. This separates correct handshake holding from a design that assumes single-cycle data. Distinct, all-ones and marker-clear table contents show whether each word lands in the right output and whether the marker check takes the run or the error path. A reset in the middle of the second read, followed by a fresh boot, shows that the sequence restarts from the base address and that the enable drops in the very cycle of the reset.

// File: rtl/bvl_pkg.sv
// Package: shared state encoding and slot indices for the vector fetch sequencer.
// Assumes a table of exactly two words: stack pointer first, handler address second.
package bvl_pkg;
    typedef enum logic [2:0] {
        BS_RESET    = 3'd0,
        BS_FETCH_SP = 3'd1,
        BS_FETCH_PC = 3'd2,
        BS_RUN      = 3'd3,
        BS_FAULT    = 3'd4
    } boot_state_e;

    localparam int unsigned NUM_VEC = 2;
    localparam int unsigned SLOT_SP = 0;
    localparam int unsigned SLOT_PC = 1;
endpackage

// File: rtl/bvl_fsm.sv
// Module: boot sequence state machine.
// Steps from reset through the two ordered reads into the run or fault state.
// Assumes rd_done is a single-cycle completion qualifier from the bus driver.
module bvl_fsm #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MARK_BIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_done,
    input  logic [DATA_W-1:0]    rd_data,
    output bvl_pkg::boot_state_e state_o
);
    import bvl_pkg::*;

    boot_state_e state_q, state_d;

    // Next-state selection for the fetch sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            BS_RESET:    state_d = BS_FETCH_SP;
            BS_FETCH_SP: if (rd_done) state_d = BS_FETCH_PC;
            BS_FETCH_PC: if (rd_done) state_d = rd_data[MARK_BIT] ? BS_RUN : BS_FAULT;
            BS_RUN:      state_d = BS_RUN;
            BS_FAULT:    state_d = BS_FAULT;
            default:     state_d = BS_RESET;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BS_RESET;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R7: run is only ever entered straight from the handler-address read.
    p_run_from_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_RUN && $past(state_q) != BS_RUN) |-> $past(state_q) == BS_FETCH_PC);

    // R8: the fault state is left only through reset.
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == BS_FAULT |=> state_q == BS_FAULT);

    // R5: the second read always follows the first.
    p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_FETCH_PC && $past(state_q) != BS_FETCH_PC) |-> $past(state_q) == BS_FETCH_SP);
endmodule

// File: rtl/bvl_bus_drv.sv
// Module: read request driver for the vector table.
// Turns the fetch state into a request, a slot index and a slot address.
// Assumes the responder completes a read by raising ready while the request is high.
module bvl_bus_drv #(
    parameter int unsigned          ADDR_W     = 32,
    parameter int unsigned          WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0]    VEC_BASE   = '0,
    parameter int unsigned          IDX_W      = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bvl_pkg::boot_state_e state_i,
    input  logic                 bus_ready,
    output logic                 bus_req,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 rd_done,
    output logic [IDX_W-1:0]     rd_idx
);
    import bvl_pkg::*;

    logic [ADDR_W-1:0] slot_addr [NUM_VEC];
    logic              fetching;

    // One fixed address per table slot, spaced by the word size.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_slot
        assign slot_addr[g] = VEC_BASE + ADDR_W'(g * WORD_BYTES);
    end

    // Request and slot selection derived from the current state.
    always_comb begin
        fetching = (state_i == BS_FETCH_SP) || (state_i == BS_FETCH_PC);
        rd_idx   = (state_i == BS_FETCH_PC) ? IDX_W'(SLOT_PC) : IDX_W'(SLOT_SP);
        bus_req  = rst_n && fetching;
        bus_addr = slot_addr[rd_idx];
        rd_done  = bus_req && bus_ready;
    end

    // R3: an unanswered request holds its address into the next cycle.
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)));
endmodule

// File: rtl/bvl_vec_regs.sv
// Module: capture registers for the two table words and the load strobe.
// Each slot register loads on its own read completion and holds otherwise.
// Assumes rd_idx is valid whenever rd_done is high.
module bvl_vec_regs #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MARK_BIT = 0,
    parameter int unsigned IDX_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_done,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sp_o,
    output logic [DATA_W-1:0] pc_o,
    output logic              load_stb_o
);
    import bvl_pkg::*;

    logic [DATA_W-1:0] slot_q [NUM_VEC];
    logic              stb_q;

    // Slot capture: the completing read writes only its own slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_VEC; i++) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (rd_done && rd_idx == IDX_W'(i))
                slot_q[i] <= rd_data;
        end
    end

    // Strobe: one pulse after a handler address with its marker bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= rd_done && (rd_idx == IDX_W'(SLOT_PC)) && rd_data[MARK_BIT];
    end

    assign sp_o       = slot_q[SLOT_SP];
    assign pc_o       = slot_q[SLOT_PC];
    assign load_stb_o = stb_q;

    // R7: the strobe never lasts longer than one cycle.
    p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb_o |=> !load_stb_o);

    // R6: a strobed handler address always carries the marker bit.
    p_stb_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb_o |-> pc_o[MARK_BIT]);
endmodule

// File: rtl/boot_vec_loader.sv
// Module: reset vector fetch sequencer (top).
// After reset, reads the stack pointer and handler address from the table,
// then enables the core, or flags a broken handler address and stays halted.
// Assumes a synchronous active-low reset and a request/ready read responder.
module boot_vec_loader #(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] VEC_BASE   = '0,
    parameter int unsigned       MARK_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              load_stb,
    output logic              core_en,
    output logic              vec_err
);
    import bvl_pkg::*;

    localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    boot_state_e      state;
    logic             rd_done;
    logic [IDX_W-1:0] rd_idx;

    bvl_fsm #(.DATA_W(DATA_W), .MARK_BIT(MARK_BIT)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_done (rd_done),
        .rd_data (bus_rdata),
        .state_o (state)
    );

    bvl_bus_drv #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
                  .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .bus_ready (bus_ready),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .rd_done   (rd_done),
        .rd_idx    (rd_idx)
    );

    bvl_vec_regs #(.DATA_W(DATA_W), .MARK_BIT(MARK_BIT), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_done    (rd_done),
        .rd_idx     (rd_idx),
        .rd_data    (bus_rdata),
        .sp_o       (sp_out),
        .pc_o       (pc_out),
        .load_stb_o (load_stb)
    );

    // Core enable drops in the very cycle reset is driven low.
    always_comb begin
        core_en = rst_n && (state == BS_RUN);
        vec_err = (state == BS_FAULT);
    end

    // R9: reset low silences the enable and the bus in the same cycle.
    p_rst_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (!core_en && !bus_req));

    // R8: an error never coexists with an enabled core.
    p_err_no_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err |-> !core_en);

    // R10: the bus is idle once the core runs.
    p_run_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> !bus_req);

    // R2: every new request sequence begins at the table base.
    p_first_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> bus_addr == VEC_BASE);

    // R10: the captured words stay put while running.
    p_hold_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |=> ($stable(sp_out) && $stable(pc_out)));
endmodule

// File: tb/boot_vec_loader_test.sv
`timescale 1ns/1ps
module boot_vec_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req, bus_ready = 1'b0;
    logic [31:0] bus_addr, bus_rdata = '0;
    logic [31:0] sp_out, pc_out;
    logic        load_stb, core_en, vec_err;

    always #2.5 clk = ~clk;

    boot_vec_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .sp_out(sp_out),
        .pc_out(pc_out), .load_stb(load_stb), .core_en(core_en), .vec_err(vec_err)
    );

    localparam int K_READ = 0, K_DONE = 1, K_ERR = 2;
    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [31:0] b;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_tests = 0, n_fail = 0;
    logic [31:0] mem_sp = '0, mem_pc = '0;
    int          w_sp = 0, w_pc = 0, wcnt = 0;
    bit          run_seen = 0, err_seen = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t pop_expect(input int kind);
        exp_t e;
        if (sb.size() == 0) begin
            e.kind = -1; e.a = '0; e.b = '0; e.tag = "unexpected";
        end else begin
            e = sb.pop_front();
        end
        return e;
    endfunction

    // Responder and scoreboard monitor: drive ready/data and compare at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0; wcnt = 0; run_seen = 0; err_seen = 0;
        end else begin
            if (bus_req) begin
                if (wcnt < ((bus_addr == 32'h0) ? w_sp : w_pc)) begin
                    bus_ready = 1'b0; wcnt++;
                end else begin
                    exp_t e;
                    bus_ready = 1'b1;
                    bus_rdata = (bus_addr == 32'h0) ? mem_sp : mem_pc;
                    wcnt = 0;
                    e = pop_expect(K_READ);
                    check(e.kind == K_READ && bus_addr == e.a, {"read order/address ", e.tag}, bus_addr, e.a);
                end
            end else begin
                bus_ready = 1'b0; wcnt = 0;
            end
            if (load_stb) begin
                exp_t e;
                e = pop_expect(K_DONE);
                check(e.kind == K_DONE && sp_out == e.a, "R4 sp_out at strobe", sp_out, e.a);
                check(e.kind == K_DONE && pc_out == e.b, "R6 pc_out at strobe", pc_out, e.b);
                check(core_en, "R7 core_en with strobe", {31'b0, core_en}, 32'h1);
                run_seen = 1;
            end
            if (core_en && !run_seen)
                check(0, "R7 core_en before strobe", {31'b0, core_en}, 32'h0);
            if (vec_err && !err_seen) begin
                exp_t e;
                e = pop_expect(K_ERR);
                check(e.kind == K_ERR && pc_out == e.b, "R8 error raised for handler", pc_out, e.b);
                check(!core_en, "R8 no enable on error", {31'b0, core_en}, 32'h0);
                err_seen = 1;
            end
        end
    end

    // Driver: load the table model, queue the expected reads and outcome, release reset.
    task automatic boot(input logic [31:0] sp, input logic [31:0] pc, input int ws, input int wp,
                        input bit wait_done);
        exp_t e;
        mem_sp = sp; mem_pc = pc; w_sp = ws; w_pc = wp;
        e.kind = K_READ; e.a = 32'h0; e.b = '0; e.tag = "R2 base word"; sb.push_back(e);
        e.kind = K_READ; e.a = 32'h4; e.tag = "R5 second word"; sb.push_back(e);
        e.kind = pc[0] ? K_DONE : K_ERR; e.a = sp; e.b = pc; e.tag = "outcome"; sb.push_back(e);
        @(negedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check(bus_req && bus_addr == 32'h0, "R2 first request at base", bus_addr, 32'h0);
        if (wait_done) begin
            int t = 0;
            while (sb.size() != 0 && t < 300) begin
                @(posedge clk); t++;
            end
            @(negedge clk); #1;
            check(sb.size() == 0, "R5 sequence completes (timeout)", sb.size(), 0);
        end
    endtask

    // Reset asserted between falling and rising edges; enable must drop at once.
    task automatic do_reset();
        @(negedge clk); #1 rst_n = 1'b0;
        #0.5;
        check(!core_en && !bus_req, "R9 same-cycle drop", {30'b0, core_en, bus_req}, 32'h0);
        repeat (3) @(posedge clk);
        sb.delete();
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        check(!core_en && !bus_req && !load_stb && !vec_err, "R1 reset outputs",
              {28'b0, core_en, bus_req, load_stb, vec_err}, 32'h0);
        check(sp_out == 0 && pc_out == 0, "R1 reset registers", sp_out | pc_out, 32'h0);

        // Zero-wait boot with an odd handler address.
        boot(32'h2000_1000, 32'h0000_0101, 0, 0, 1);
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        check(core_en && !bus_req, "R10 bus idle while running", {30'b0, core_en, bus_req}, 32'h2);
        check(sp_out == 32'h2000_1000 && pc_out == 32'h0000_0101, "R10 values held", pc_out, 32'h0000_0101);

        // Wait cycles on both reads.
        do_reset();
        check(sp_out == 0 && pc_out == 0 && !vec_err, "R1 registers cleared by reset", sp_out, 32'h0);
        boot(32'h2000_7FF0, 32'h0000_0A41, 3, 5, 1);
        check(core_en, "R3 boot with wait states", {31'b0, core_en}, 32'h1);

        // Marker bit clear: fault path.
        do_reset();
        boot(32'h2000_0400, 32'h0000_0200, 1, 2, 1);
        repeat (10) @(posedge clk);
        @(negedge clk); #1;
        check(vec_err && !core_en && !bus_req, "R8 fault sticky and quiet",
              {29'b0, vec_err, core_en, bus_req}, 32'h4);

        // Reset in the middle of the second read, then a clean restart.
        do_reset();
        boot(32'h1111_2220, 32'h0000_3331, 0, 20, 0);
        repeat (6) @(posedge clk);
        @(negedge clk); #1;
        check(bus_req && bus_addr == 32'h4, "R5 second read pending", bus_addr, 32'h4);
        do_reset();
        check(!core_en && !vec_err, "R9 state cleared mid-fetch", {30'b0, core_en, vec_err}, 32'h0);
        boot(32'h2000_0000, 32'h0000_0801, 1, 0, 1);
        check(core_en && pc_out == 32'h0000_0801, "R9 restart boots from base", pc_out, 32'h0000_0801);

        // All-ones words.
        do_reset();
        boot(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 1);
        check(sp_out == 32'hFFFF_FFFF, "R4 all-ones stack pointer", sp_out, 32'hFFFF_FFFF);
        check(pc_out == 32'hFFFF_FFFF, "R6 all-ones handler", pc_out, 32'hFFFF_FFFF);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule